// File: doc/BRIEF.md
# Timeslot Power Rail Sequencer

The sequencer drives the enables of a bank of power rails through four power transitions: power-up, power-down, entry into sleep and return from sleep. Each rail has two 3-bit fields. The start field gives the timeslot in which the rail turns on. It can instead hand the rail to one of the hardware enable inputs. The sleep field gives the timeslot in which the rail is either turned off or moved to its low-power configuration on entry to sleep.

Power-down replays the start order backwards, and wake replays the sleep order backwards. Each timeslot lasts a programmable number of clock cycles. The sequencer keeps a software enable bit for every rail it sequences. A rail handed to a hardware enable input follows that input's level from the end of power-up until power-down begins.

An off request made while asleep skips the timed sequence. Every rail drops on the next clock edge. Requests that arrive while a sequence is running are held and are taken up once it completes.

Top module: `rail_sequencer`

## Requirements
- R1: Start-field encoding: 0 means no slot, 1 to 5 are timeslots, 6 selects hardware enable input 0 and 7 selects input 1. In the power-up sequence, the rails whose start field equals slot s turn on at clock edge 1+(s-1)·L after the edge that samples the request, where L is the tick length.
- R2: Power-down visits the slots in the order 5, 4, 3, 2, 1. Rails whose start field equals the k-th slot visited (k counted from 0) turn off at edge 1+k·L after the request edge.
- R3: At the first edge of power-down, rails with start field 0 turn off, and rails under hardware enable stop following their input.
- R4: A rail with start field 6 or 7 drives its enable output from the selected hardware input, with no register on the path, while the block is in ON, SLEEP, or a sleep or wake sequence. Outside those states the rail's output is 0.
- R5: Sleep entry visits slots 1 to 5. At a rail's sleep slot, a rail with its sleep-off mask bit set that is not under hardware enable turns off. Every other rail whose sleep field matches the slot sets its sleep-configuration output.
- R6: Wake visits slots 5 down to 1. At a rail's sleep slot, its sleep-configuration output clears. The rail turns back on only if the sleep sequence turned it off.
- R7: The software enable bit of a rail under hardware enable is never written by any sequence.
- R8: An off request in the SLEEP state, or during a sleep or wake sequence, reaches OFF at the next edge. At that edge all software enables and sleep outputs clear and no sequence runs.
- R9: The slot fields and the sleep-off mask may change between sequences. Each sequence uses the values present while it runs.
- R10: The done output pulses for one cycle at edge 5·L after the request edge, together with the move to the stable state. A tick length of 0 acts as 1.
- R11: A request made while busy is held and acted on at the edge after completion, except as R8 states. Requests that do not apply to the current stable state are dropped.
- R12: After reset all rail outputs, software enables and sleep outputs are 0, the power state reads OFF (code 0) and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Power-up request pulse |
| req_off | input | 1 | Power-down request pulse |
| req_sleep | input | 1 | Sleep entry request pulse |
| req_wake | input | 1 | Wake request pulse |
| tick_len | input | TICK_W | Clock cycles per timeslot (0 acts as 1) |
| on_slot | input | N_RAILS*SLOT_W | Start fields, rail i at bits [i*SLOT_W +: SLOT_W] |
| slp_slot | input | N_RAILS*SLOT_W | Sleep fields, same packing |
| slp_off_mask | input | N_RAILS | 1: the rail turns off in sleep; 0: it takes its sleep configuration |
| hw_en_in | input | N_HW | Hardware enable inputs |
| rail_en | output | N_RAILS | Per-rail enable |
| rail_sleep | output | N_RAILS | Per-rail sleep-configuration select |
| sw_ena | output | N_RAILS | Software enable bits kept by the sequencer |
| pwr_state | output | 2 | 0 OFF, 1 ON, 2 SLEEP; the target state while busy |
| busy | output | 1 | A sequence is running |
| seq_done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
A request sampled at edge E0 produces its first slot effect at E0+1 and each later slot L edges after the one before. The done pulse and the stable state arrive at E0+5·L. The immediate power-down effects and the sleep-to-off shutdown appear at E0+1, while hardware enable levels reach the rail outputs in the same cycle. The bench drives inputs on the falling edge and computes each expected snapshot from the cycle number of that edge. A monitor compares snapshots one nanosecond after a falling edge, only at the cycle they are due, and counts a snapshot left behind as a failure. A held request is modelled as if it had been sampled one edge after the done edge.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_SEQ_ON   = 3'd1,
    ST_ON       = 3'd2,
    ST_SEQ_OFF  = 3'd3,
    ST_SEQ_SLP  = 3'd4,
    ST_SLEEP    = 3'd5,
    ST_SEQ_WAKE = 3'd6
  } pseq_state_e;

  localparam logic [1:0] PWR_OFF   = 2'd0;
  localparam logic [1:0] PWR_ON    = 2'd1;
  localparam logic [1:0] PWR_SLEEP = 2'd2;

endpackage

// File: rtl/rseq_walker.sv
module rseq_walker #(
  parameter int N_SLOTS = 5,
  parameter int SLOT_W  = 3,
  parameter int TICK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              desc,
  input  logic              abort,
  input  logic [TICK_W-1:0] tick_len,
  output logic              strobe,
  output logic [SLOT_W-1:0] slot,
  output logic              finish
);

  localparam logic [SLOT_W-1:0] FIRST_UP = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(N_SLOTS);

  logic              run_q, run_d;
  logic              desc_q, desc_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic [TICK_W-1:0] len_m1;
  logic [SLOT_W-1:0] last_slot;
  logic              at_end;

  always_comb begin
    len_m1    = (tick_len == '0) ? '0 : tick_len - 1'b1;
    last_slot = desc_q ? FIRST_UP : TOP_SLOT;
    at_end    = (cnt_q >= len_m1);
    strobe    = run_q && (cnt_q == '0);
    finish    = run_q && at_end && (slot_q == last_slot);
    slot      = slot_q;
  end

  always_comb begin
    run_d  = run_q;
    desc_d = desc_q;
    slot_d = slot_q;
    cnt_d  = cnt_q;
    if (abort) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (start) begin
      run_d  = 1'b1;
      desc_d = desc;
      slot_d = desc ? TOP_SLOT : FIRST_UP;
      cnt_d  = '0;
    end else if (run_q) begin
      if (at_end) begin
        cnt_d = '0;
        if (slot_q == last_slot) begin
          run_d = 1'b0;
        end else begin
          slot_d = desc_q ? slot_q - 1'b1 : slot_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      desc_q <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      desc_q <= desc_d;
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/rseq_decode.sv
module rseq_decode #(
  parameter int N_RAILS = 17,
  parameter int SLOT_W  = 3,
  parameter int N_SLOTS = 5,
  parameter int N_HW    = 2
) (
  input  logic [N_RAILS*SLOT_W-1:0] on_slot,
  input  logic [N_RAILS*SLOT_W-1:0] slp_slot,
  input  logic [SLOT_W-1:0]         slot,
  input  logic [N_HW-1:0]           hw_en_in,
  output logic [N_RAILS-1:0]        on_hit,
  output logic [N_RAILS-1:0]        slp_hit,
  output logic [N_RAILS-1:0]        is_hw,
  output logic [N_RAILS-1:0]        is_unas,
  output logic [N_RAILS-1:0]        hw_lvl
);

  localparam int HW_BASE = N_SLOTS + 1;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    logic [SLOT_W-1:0] on_f;
    logic [SLOT_W-1:0] slp_f;

    assign on_f  = on_slot[i*SLOT_W +: SLOT_W];
    assign slp_f = slp_slot[i*SLOT_W +: SLOT_W];

    always_comb begin
      on_hit[i]  = (on_f == slot);
      slp_hit[i] = (slp_f == slot);
      is_unas[i] = (on_f == '0);
      is_hw[i]   = (on_f >= SLOT_W'(HW_BASE));
      hw_lvl[i]  = 1'b0;
      for (int h = 0; h < N_HW; h++) begin
        if (on_f == SLOT_W'(HW_BASE + h)) hw_lvl[i] = hw_en_in[h];
      end
    end
  end

endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_on,
  input  logic        req_off,
  input  logic        req_sleep,
  input  logic        req_wake,
  input  logic        finish,
  output pseq_state_e state,
  output logic        walk_start,
  output logic        walk_desc,
  output logic        walk_abort,
  output logic        off_start,
  output logic        kill,
  output logic        hw_window,
  output logic        busy,
  output logic        seq_done,
  output logic [1:0]  pwr_state
);

  // pending request bits: [0] on, [1] off, [2] sleep, [3] wake
  logic [3:0]  pend_q, pend_d;
  logic [3:0]  req_v, eff;
  pseq_state_e state_q, state_d;
  logic        done_q, done_d;

  assign req_v = {req_wake, req_sleep, req_off, req_on};
  assign eff   = req_v | pend_q;

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    done_d     = 1'b0;
    walk_start = 1'b0;
    walk_desc  = 1'b0;
    walk_abort = 1'b0;
    off_start  = 1'b0;
    kill       = 1'b0;
    case (state_q)
      ST_OFF: begin
        pend_d = '0;
        if (eff[0]) begin
          state_d    = ST_SEQ_ON;
          walk_start = 1'b1;
        end
      end
      ST_ON: begin
        pend_d = '0;
        if (eff[1]) begin
          state_d    = ST_SEQ_OFF;
          walk_start = 1'b1;
          walk_desc  = 1'b1;
          off_start  = 1'b1;
        end else if (eff[2]) begin
          state_d    = ST_SEQ_SLP;
          walk_start = 1'b1;
        end
      end
      ST_SLEEP: begin
        pend_d = '0;
        if (eff[1]) begin
          state_d = ST_OFF;
          kill    = 1'b1;
        end else if (eff[3]) begin
          state_d    = ST_SEQ_WAKE;
          walk_start = 1'b1;
          walk_desc  = 1'b1;
        end
      end
      ST_SEQ_SLP, ST_SEQ_WAKE: begin
        if (req_off) begin
          state_d    = ST_OFF;
          kill       = 1'b1;
          walk_abort = 1'b1;
          pend_d     = '0;
        end else begin
          pend_d = pend_q | req_v;
          if (finish) begin
            state_d = (state_q == ST_SEQ_SLP) ? ST_SLEEP : ST_ON;
            done_d  = 1'b1;
          end
        end
      end
      ST_SEQ_ON, ST_SEQ_OFF: begin
        pend_d = pend_q | req_v;
        if (finish) begin
          state_d = (state_q == ST_SEQ_ON) ? ST_ON : ST_OFF;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_OFF;
        pend_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    state     = state_q;
    seq_done  = done_q;
    busy      = (state_q == ST_SEQ_ON) || (state_q == ST_SEQ_OFF) ||
                (state_q == ST_SEQ_SLP) || (state_q == ST_SEQ_WAKE);
    hw_window = (state_q == ST_ON) || (state_q == ST_SLEEP) ||
                (state_q == ST_SEQ_SLP) || (state_q == ST_SEQ_WAKE);
    case (state_q)
      ST_SEQ_ON, ST_ON, ST_SEQ_WAKE: pwr_state = PWR_ON;
      ST_SEQ_SLP, ST_SLEEP:          pwr_state = PWR_SLEEP;
      default:                       pwr_state = PWR_OFF;
    endcase
  end

endmodule

// File: rtl/rseq_bank.sv
module rseq_bank
  import rseq_pkg::*;
#(
  parameter int N_RAILS = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  pseq_state_e        kind,
  input  logic               off_start,
  input  logic               kill,
  input  logic [N_RAILS-1:0] on_hit,
  input  logic [N_RAILS-1:0] slp_hit,
  input  logic [N_RAILS-1:0] is_hw,
  input  logic [N_RAILS-1:0] is_unas,
  input  logic [N_RAILS-1:0] hw_lvl,
  input  logic [N_RAILS-1:0] slp_off_mask,
  input  logic               hw_window,
  output logic [N_RAILS-1:0] sw_ena,
  output logic [N_RAILS-1:0] rail_sleep,
  output logic [N_RAILS-1:0] rail_en
);

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    logic sw_q, sw_d;
    logic slp_q, slp_d;
    logic dis_q, dis_d;

    always_comb begin
      sw_d  = sw_q;
      slp_d = slp_q;
      dis_d = dis_q;
      if (kill) begin
        if (!is_hw[i]) sw_d = 1'b0;
        slp_d = 1'b0;
        dis_d = 1'b0;
      end else begin
        if (off_start && is_unas[i]) sw_d = 1'b0;
        if (strobe) begin
          case (kind)
            ST_SEQ_ON: begin
              if (on_hit[i] && !is_hw[i]) sw_d = 1'b1;
            end
            ST_SEQ_OFF: begin
              if (on_hit[i] && !is_hw[i]) sw_d = 1'b0;
            end
            ST_SEQ_SLP: begin
              if (slp_hit[i]) begin
                if (slp_off_mask[i] && !is_hw[i]) begin
                  dis_d = sw_q;
                  sw_d  = 1'b0;
                end else begin
                  slp_d = 1'b1;
                end
              end
            end
            ST_SEQ_WAKE: begin
              if (slp_hit[i]) begin
                slp_d = 1'b0;
                if (dis_q) begin
                  sw_d  = 1'b1;
                  dis_d = 1'b0;
                end
              end
            end
            default: ;
          endcase
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sw_q  <= 1'b0;
        slp_q <= 1'b0;
        dis_q <= 1'b0;
      end else begin
        sw_q  <= sw_d;
        slp_q <= slp_d;
        dis_q <= dis_d;
      end
    end

    assign sw_ena[i]     = sw_q;
    assign rail_sleep[i] = slp_q;
    assign rail_en[i]    = is_hw[i] ? (hw_window & hw_lvl[i]) : sw_q;
  end

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int N_RAILS = 17,
  parameter int SLOT_W  = 3,
  parameter int N_SLOTS = 5,
  parameter int TICK_W  = 8,
  parameter int N_HW    = (1 << SLOT_W) - (N_SLOTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_on,
  input  logic                      req_off,
  input  logic                      req_sleep,
  input  logic                      req_wake,
  input  logic [TICK_W-1:0]         tick_len,
  input  logic [N_RAILS*SLOT_W-1:0] on_slot,
  input  logic [N_RAILS*SLOT_W-1:0] slp_slot,
  input  logic [N_RAILS-1:0]        slp_off_mask,
  input  logic [N_HW-1:0]           hw_en_in,
  output logic [N_RAILS-1:0]        rail_en,
  output logic [N_RAILS-1:0]        rail_sleep,
  output logic [N_RAILS-1:0]        sw_ena,
  output logic [1:0]                pwr_state,
  output logic                      busy,
  output logic                      seq_done
);

  pseq_state_e        state;
  logic               walk_start, walk_desc, walk_abort;
  logic               off_start, kill, hw_window;
  logic               strobe, finish;
  logic [SLOT_W-1:0]  slot;
  logic [N_RAILS-1:0] on_hit, slp_hit, is_hw, is_unas, hw_lvl;

  rseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_on     (req_on),
    .req_off    (req_off),
    .req_sleep  (req_sleep),
    .req_wake   (req_wake),
    .finish     (finish),
    .state      (state),
    .walk_start (walk_start),
    .walk_desc  (walk_desc),
    .walk_abort (walk_abort),
    .off_start  (off_start),
    .kill       (kill),
    .hw_window  (hw_window),
    .busy       (busy),
    .seq_done   (seq_done),
    .pwr_state  (pwr_state)
  );

  rseq_walker #(
    .N_SLOTS (N_SLOTS),
    .SLOT_W  (SLOT_W),
    .TICK_W  (TICK_W)
  ) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (walk_start),
    .desc     (walk_desc),
    .abort    (walk_abort),
    .tick_len (tick_len),
    .strobe   (strobe),
    .slot     (slot),
    .finish   (finish)
  );

  rseq_decode #(
    .N_RAILS (N_RAILS),
    .SLOT_W  (SLOT_W),
    .N_SLOTS (N_SLOTS),
    .N_HW    (N_HW)
  ) u_decode (
    .on_slot  (on_slot),
    .slp_slot (slp_slot),
    .slot     (slot),
    .hw_en_in (hw_en_in),
    .on_hit   (on_hit),
    .slp_hit  (slp_hit),
    .is_hw    (is_hw),
    .is_unas  (is_unas),
    .hw_lvl   (hw_lvl)
  );

  rseq_bank #(
    .N_RAILS (N_RAILS)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .kind         (state),
    .off_start    (off_start),
    .kill         (kill),
    .on_hit       (on_hit),
    .slp_hit      (slp_hit),
    .is_hw        (is_hw),
    .is_unas      (is_unas),
    .hw_lvl       (hw_lvl),
    .slp_off_mask (slp_off_mask),
    .hw_window    (hw_window),
    .sw_ena       (sw_ena),
    .rail_sleep   (rail_sleep),
    .rail_en      (rail_en)
  );

endmodule

// File: rtl/rseq_chk.sv
module rseq_chk
  import rseq_pkg::*;
#(
  parameter int N_RAILS = 17
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_off,
  input logic [2:0]         state,
  input logic               busy,
  input logic               seq_done,
  input logic [N_RAILS-1:0] rail_en,
  input logic [N_RAILS-1:0] rail_sleep,
  input logic [N_RAILS-1:0] sw_ena,
  input logic [N_RAILS-1:0] hw_mask
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy);

  // R8
  sleep_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && req_off) |=>
      (state == ST_OFF && rail_en == '0 && rail_sleep == '0 &&
       (sw_ena & ~hw_mask) == '0));

  // R7
  hw_sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_ena ^ $past(sw_ena)) & hw_mask & $past(hw_mask)) == '0);

  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |-> (rail_en == '0 && rail_sleep == '0));

  // R5
  sleep_cfg_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_sleep != '0) |->
      (state == ST_SEQ_SLP || state == ST_SLEEP || state == ST_SEQ_WAKE));

endmodule

bind rail_sequencer rseq_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_off    (req_off),
  .state      (state),
  .busy       (busy),
  .seq_done   (seq_done),
  .rail_en    (rail_en),
  .rail_sleep (rail_sleep),
  .sw_ena     (sw_ena),
  .hw_mask    (is_hw)
);

// File: tb/sim_rail_sequencer.sv
module sim_rail_sequencer;

  localparam int N  = 17;
  localparam int SW = 3;
  localparam int NS = 5;
  localparam int TW = 8;
  localparam int NH = 2;
  localparam int K_ON = 0, K_OFF = 1, K_SLP = 2, K_WAKE = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            req_on, req_off, req_sleep, req_wake;
  logic [TW-1:0]   tick_len;
  logic [N*SW-1:0] on_slot, slp_slot;
  logic [N-1:0]    slp_off_mask;
  logic [NH-1:0]   hw_en_in;
  logic [N-1:0]    rail_en, rail_sleep, sw_ena;
  logic [1:0]      pwr_state;
  logic            busy, seq_done;

  rail_sequencer #(.N_RAILS(N), .SLOT_W(SW), .N_SLOTS(NS), .TICK_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
    .req_sleep(req_sleep), .req_wake(req_wake), .tick_len(tick_len),
    .on_slot(on_slot), .slp_slot(slp_slot), .slp_off_mask(slp_off_mask),
    .hw_en_in(hw_en_in), .rail_en(rail_en), .rail_sleep(rail_sleep),
    .sw_ena(sw_ena), .pwr_state(pwr_state), .busy(busy), .seq_done(seq_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int         cyc;
    logic [N-1:0] en;
    logic [N-1:0] slp;
    logic [N-1:0] sw;
    logic       done;
    logic [1:0] ps;
    string      tag;
  } item_t;
  item_t q[$];

  // reference model
  logic [2:0]   f_on  [N];
  logic [2:0]   f_slp [N];
  logic [N-1:0] m_sw, m_slp, m_dis;
  logic         win;
  logic [1:0]   m_ps;

  function automatic logic [N-1:0] exp_en();
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      if (f_on[i] >= 3'd6) e[i] = win & hw_en_in[f_on[i] - 3'd6];
      else                 e[i] = m_sw[i];
    end
    return e;
  endfunction

  task automatic push(int c, logic d, string tag);
    item_t it;
    it.cyc = c; it.en = exp_en(); it.slp = m_slp; it.sw = m_sw;
    it.done = d; it.ps = m_ps; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic apply_slot(int kind, int s);
    for (int i = 0; i < N; i++) begin
      logic hw;
      hw = (f_on[i] >= 3'd6);
      case (kind)
        K_ON:  if (!hw && f_on[i] == 3'(s)) m_sw[i] = 1'b1;
        K_OFF: if (!hw && f_on[i] == 3'(s)) m_sw[i] = 1'b0;
        K_SLP: if (f_slp[i] == 3'(s)) begin
          if (slp_off_mask[i] && !hw) begin m_dis[i] = m_sw[i]; m_sw[i] = 1'b0; end
          else m_slp[i] = 1'b1;
        end
        default: if (f_slp[i] == 3'(s)) begin
          m_slp[i] = 1'b0;
          if (m_dis[i]) begin m_sw[i] = 1'b1; m_dis[i] = 1'b0; end
        end
      endcase
    end
  endtask

  // base: cycle count at the falling edge where the request is (or acts as if) driven
  task automatic push_seq(int kind, int base, int len, string tag);
    if (kind == K_OFF) begin
      win = 1'b0; m_ps = 2'd0;
      for (int i = 0; i < N; i++) if (f_on[i] == 3'd0) m_sw[i] = 1'b0;
      push(base + 1, 1'b0, tag);
    end
    if (kind == K_ON || kind == K_WAKE) m_ps = 2'd1;
    if (kind == K_SLP) m_ps = 2'd2;
    for (int k = 0; k < NS; k++) begin
      int s;
      s = (kind == K_ON || kind == K_SLP) ? k + 1 : NS - k;
      apply_slot(kind, s);
      if (!(k == NS - 1 && len == 1)) push(base + 2 + k * len, 1'b0, tag);
    end
    if (kind == K_ON) win = 1'b1;
    push(base + 1 + NS * len, 1'b1, tag);
  endtask

  task automatic set_req(int w, logic v);
    case (w)
      K_ON:    req_on = v;
      K_OFF:   req_off = v;
      K_SLP:   req_sleep = v;
      default: req_wake = v;
    endcase
  endtask

  function automatic int cur_len();
    return (tick_len == '0) ? 1 : int'(tick_len);
  endfunction

  task automatic run_seq(int kind, string tag);
    @(negedge clk);
    push_seq(kind, cyc, cur_len(), tag);
    set_req(kind, 1'b1);
    @(negedge clk);
    set_req(kind, 1'b0);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic load_fields();
    for (int i = 0; i < N; i++) begin
      on_slot[i*SW +: SW]  = f_on[i];
      slp_slot[i*SW +: SW] = f_slp[i];
    end
  endtask

  // monitor: compares due snapshots 1 ns after each falling edge
  always @(negedge clk) begin
    item_t it;
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      checks++;
      if (it.cyc < cyc) begin
        errors++;
        $display("FAIL %s: snapshot for cycle %0d missed (now %0d), expected en %h", it.tag, it.cyc, cyc, it.en);
      end else if (rail_en !== it.en || rail_sleep !== it.slp || sw_ena !== it.sw ||
                   seq_done !== it.done || pwr_state !== it.ps) begin
        errors++;
        $display("FAIL %s cyc %0d: en %h exp %h, sleep %h exp %h, sw %h exp %h, done %b exp %b, state %0d exp %0d",
                 it.tag, cyc, rail_en, it.en, rail_sleep, it.slp, sw_ena, it.sw,
                 seq_done, it.done, pwr_state, it.ps);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_on = 1'b0; req_off = 1'b0; req_sleep = 1'b0; req_wake = 1'b0;
    tick_len = 8'd3;
    hw_en_in = 2'b01;
    for (int i = 0; i < N; i++) begin
      f_on[i]  = 3'(i % 8);
      f_slp[i] = 3'(((i * 3) % 5) + 1);
      slp_off_mask[i] = ~i[0];
    end
    load_fields();
    m_sw = '0; m_slp = '0; m_dis = '0; win = 1'b0; m_ps = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R12 reset state
    checks++;
    if (rail_en !== '0 || rail_sleep !== '0 || sw_ena !== '0 || pwr_state !== 2'd0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R12: en %h sleep %h sw %h state %0d busy %b, expected all 0", rail_en, rail_sleep, sw_ena, pwr_state, busy);
    end

    // R1 R10: power-up with L=3
    run_seq(K_ON, "R1 R10 power-up");
    drain();

    // R4: hardware inputs drive their rails directly
    @(negedge clk);
    hw_en_in = 2'b10;
    push(cyc, 1'b0, "R4 hw follow");
    drain();

    // R11: requests that do not apply in ON are dropped
    @(negedge clk);
    push(cyc + 1, 1'b0, "R11 ignored");
    push(cyc + 3, 1'b0, "R11 ignored");
    req_on = 1'b1; req_wake = 1'b1;
    @(negedge clk);
    req_on = 1'b0; req_wake = 1'b0;
    drain();

    // R5 then R6
    run_seq(K_SLP, "R5 sleep entry");
    drain();
    run_seq(K_WAKE, "R6 wake");
    drain();

    // R8: off request while asleep
    run_seq(K_SLP, "R5 sleep again");
    drain();
    @(negedge clk);
    for (int i = 0; i < N; i++) if (f_on[i] < 3'd6) m_sw[i] = 1'b0;
    m_slp = '0; m_dis = '0; win = 1'b0; m_ps = 2'd0;
    push(cyc + 1, 1'b0, "R8 sleep to off");
    req_off = 1'b1;
    @(negedge clk);
    req_off = 1'b0;
    drain();

    // R10 tick 0 acts as 1, R11 sleep request held during power-up
    tick_len = 8'd0;
    @(negedge clk);
    begin
      int c0;
      c0 = cyc;
      push_seq(K_ON, c0, 1, "R10 tick0 power-up");
      req_on = 1'b1;
      @(negedge clk);
      req_on = 1'b0;
      @(negedge clk);
      req_sleep = 1'b1;
      @(negedge clk);
      req_sleep = 1'b0;
      push_seq(K_SLP, c0 + 1 + NS, 1, "R11 held sleep");
    end
    drain();
    tick_len = 8'd2;
    run_seq(K_WAKE, "R6 wake L2");
    drain();

    // R9: rail 1 moves from slot 1 to slot 4 before power-down; R2 R3
    f_on[1] = 3'd4;
    load_fields();
    run_seq(K_OFF, "R2 R3 R9 power-down");
    drain();

    @(negedge clk);
    #1;
    checks++;
    if (rail_en !== '0 || busy !== 1'b0 || pwr_state !== 2'd0) begin
      errors++;
      $display("FAIL R2: after power-down en %h busy %b state %0d, expected 0 0 0", rail_en, busy, pwr_state);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule